// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with HI/LO Result Pair

This unit performs 32-bit integer multiplication and division over many clock cycles and keeps its results in a dedicated pair of 32-bit registers, HI and LO. A multiply leaves the 64-bit product split across the pair: the upper word in HI and the lower word in LO. A divide leaves the quotient in LO and the remainder in HI. An accumulating multiply adds the signed product to the 64-bit value already held in {HI, LO}. Two direct-load commands let software write either register from the first operand.

A command is issued by raising `start_i` for one cycle with the operands and an opcode. Multiply and divide commands keep `busy_o` high while they iterate, and any read of HI or LO requested in that time is refused (`rd_valid_o` low) until the unit is idle again. Instruction decode and the general register file sit outside this block.

Top module: `mdu_core`

## Requirements
- R1: After reset HI and LO read as zero and `busy_o` is low.
- R2: Opcode 0 (signed multiply) writes the two's-complement 64-bit product of `a_i` and `b_i`, upper word to HI and lower word to LO.
- R3: Opcode 1 (unsigned multiply) writes the unsigned 64-bit product of `a_i` and `b_i`, upper word to HI and lower word to LO.
- R4: Opcode 2 (signed divide) writes the quotient, truncated toward zero, to LO and the remainder, carrying the sign of the dividend, to HI; 0x80000000 divided by -1 gives quotient 0x80000000 and remainder 0.
- R5: Opcode 3 (unsigned divide) writes the unsigned quotient to LO and the unsigned remainder to HI.
- R6: A divide (opcode 2 or 3) with `b_i` zero raises no error and writes LO = 0xFFFFFFFF and HI = `a_i`.
- R7: Opcode 4 (multiply-accumulate) adds the signed 64-bit product of `a_i` and `b_i` to {HI, LO}, wrapping modulo 2^64, and writes the sum back.
- R8: Opcode 5 loads `a_i` into HI and opcode 6 loads `a_i` into LO at the next clock edge, without raising `busy_o` and leaving the other register unchanged.
- R9: An accepted opcode 0 to 4 raises `busy_o` at the next edge and holds it for exactly 32 cycles; the result is readable in the first cycle with `busy_o` low.
- R10: A read (`rd_req_i` high; `rd_hi_i` high selects HI, low selects LO) gives `rd_valid_o` high with the selected register on `rd_data_o` only when `busy_o` is low; while busy, `rd_valid_o` stays low.
- R11: `start_i` while `busy_o` is high, and opcode 7 at any time, change neither HI, LO nor the length of the busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe, one cycle |
| op_i | input | 3 | Opcode (0 to 7) |
| a_i | input | 32 | First operand / dividend / load value |
| b_i | input | 32 | Second operand / divisor |
| busy_o | output | 1 | Multiply or divide in progress |
| rd_req_i | input | 1 | Read request |
| rd_hi_i | input | 1 | Read select: 1 for HI, 0 for LO |
| rd_valid_o | output | 1 | Read granted this cycle |
| rd_data_o | output | 32 | Selected register value |

## Verification
Assertions watch on every cycle that an accepted arithmetic command raises busy, that a busy run never exceeds 32 cycles and ends on the 32nd, that HI and LO do not move in the middle of a run, that direct loads touch only their target, that the partial remainder stays below a nonzero divisor and that a zero divisor yields an all-ones quotient. Whether the numeric results are right for signed and unsigned operands, for the most negative dividend, for accumulation carries and wraparound, and whether stray commands during a run are truly ignored, only the bench's reference model can show by comparing reads on every clock.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [2:0] {
    OP_MUL  = 3'd0,
    OP_MULU = 3'd1,
    OP_DIV  = 3'd2,
    OP_DIVU = 3'd3,
    OP_MADD = 3'd4,
    OP_MTHI = 3'd5,
    OP_MTLO = 3'd6,
    OP_NOP  = 3'd7
  } mdu_op_e;
endpackage

// File: rtl/mdu_mul.sv
module mdu_mul #(
  parameter int W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] prod_nxt_o
);
  logic [W-1:0]   mcand_q;
  logic [2*W-1:0] prod_q;
  logic [W:0]     sum;

  // shift-add: one multiplier bit per step, product grows from the top
  always_comb begin
    sum        = {1'b0, prod_q[2*W-1:W]} + (prod_q[0] ? {1'b0, mcand_q} : '0);
    prod_nxt_o = {sum, prod_q[W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      prod_q  <= {{W{1'b0}}, mplier_i};
    end else if (step_i) begin
      prod_q  <= prod_nxt_o;
    end
  end
endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] quo_nxt_o,
  output logic [W-1:0] rem_nxt_o
);
  logic [W-1:0] dvs_q, quo_q, rem_q;
  logic [W:0]   r_sh, diff;
  logic         ge;

  // restoring division; a zero divisor naturally gives all-ones / dividend
  always_comb begin
    r_sh      = {rem_q, quo_q[W-1]};
    diff      = r_sh - {1'b0, dvs_q};
    ge        = r_sh >= {1'b0, dvs_q};
    quo_nxt_o = {quo_q[W-2:0], ge};
    rem_nxt_o = ge ? diff[W-1:0] : r_sh[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvs_q <= '0;
      quo_q <= '0;
      rem_q <= '0;
    end else if (load_i) begin
      dvs_q <= dvs_i;
      quo_q <= dvd_i;
      rem_q <= '0;
    end else if (step_i) begin
      quo_q <= quo_nxt_o;
      rem_q <= rem_nxt_o;
    end
  end

  AST_REM_BELOW_DVS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dvs_q == '0) || (rem_q < dvs_q)); // R5
endmodule

// File: rtl/mdu_core.sv
module mdu_core
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  input  logic         rd_req_i,
  input  logic         rd_hi_i,
  output logic         rd_valid_o,
  output logic [W-1:0] rd_data_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  mdu_op_e       op, op_q;
  logic          busy_q, accept, is_mul, is_div, sgn, a_neg, b_neg;
  logic          neg_res_q, neg_rem_q, dz_q, done;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  mag_a, mag_b, dvd_q, hi_q, lo_q;
  logic [W-1:0]  quo_nxt, rem_nxt, quo_fix, rem_fix;
  logic [2*W-1:0] prod_nxt, prod_fix, res;

  assign op     = mdu_op_e'(op_i);
  assign accept = start_i && !busy_q;
  assign is_mul = (op == OP_MUL) || (op == OP_MULU) || (op == OP_MADD);
  assign is_div = (op == OP_DIV) || (op == OP_DIVU);
  assign sgn    = (op == OP_MUL) || (op == OP_DIV) || (op == OP_MADD);
  assign a_neg  = sgn && a_i[W-1];
  assign b_neg  = sgn && b_i[W-1];
  assign mag_a  = a_neg ? -a_i : a_i;
  assign mag_b  = b_neg ? -b_i : b_i;
  assign done   = busy_q && (cnt_q == LAST);

  mdu_mul #(.W(W)) u_mul (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept && is_mul),
    .step_i     (busy_q),
    .mcand_i    (mag_a),
    .mplier_i   (mag_b),
    .prod_nxt_o (prod_nxt)
  );

  mdu_div #(.W(W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept && is_div),
    .step_i    (busy_q),
    .dvd_i     (mag_a),
    .dvs_i     (mag_b),
    .quo_nxt_o (quo_nxt),
    .rem_nxt_o (rem_nxt)
  );

  // sign fix-up and final result selection on the last step
  always_comb begin
    prod_fix = neg_res_q ? -prod_nxt : prod_nxt;
    quo_fix  = neg_res_q ? -quo_nxt  : quo_nxt;
    rem_fix  = neg_rem_q ? -rem_nxt  : rem_nxt;
    unique case (op_q)
      OP_MADD:          res = {hi_q, lo_q} + prod_fix;
      OP_DIV, OP_DIVU:  res = dz_q ? {dvd_q, {W{1'b1}}} : {rem_fix, quo_fix};
      default:          res = prod_fix;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      op_q      <= OP_NOP;
      neg_res_q <= 1'b0;
      neg_rem_q <= 1'b0;
      dz_q      <= 1'b0;
      dvd_q     <= '0;
      hi_q      <= '0;
      lo_q      <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (done) begin
        busy_q       <= 1'b0;
        {hi_q, lo_q} <= res;
      end
    end else if (start_i) begin
      if (is_mul || is_div) begin
        busy_q    <= 1'b1;
        cnt_q     <= '0;
        op_q      <= op;
        neg_res_q <= a_neg ^ b_neg;
        neg_rem_q <= a_neg;
        dz_q      <= (b_i == '0);
        dvd_q     <= a_i;
      end else if (op == OP_MTHI) begin
        hi_q <= a_i;
      end else if (op == OP_MTLO) begin
        lo_q <= a_i;
      end
    end
  end

  assign busy_o     = busy_q;
  assign rd_valid_o = rd_req_i && !busy_q;
  assign rd_data_o  = rd_hi_i ? hi_q : lo_q;

  // independent run-length counter for the busy window
  logic [CW:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  AST_MD_RAISES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && (is_mul || is_div)) |=> busy_o); // R9
  AST_BUSY_NOT_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (run_q < (CW+1)'(W))); // R9
  AST_BUSY_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && run_q == (CW+1)'(W - 1)) |=> !busy_o); // R9
  AST_HOLD_MID_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_o) && busy_o) |-> ($stable(hi_q) && $stable(lo_q))); // R11
  AST_LOAD_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && op == OP_MTHI) |=> (hi_q == $past(a_i) && $stable(lo_q) && !busy_o)); // R8
  AST_LOAD_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && op == OP_MTLO) |=> (lo_q == $past(a_i) && $stable(hi_q) && !busy_o)); // R8
  AST_DIV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && dz_q && (op_q == OP_DIV || op_q == OP_DIVU)) |=> (lo_q == '1)); // R6
endmodule

// File: tb/tb_mdu_core.sv
`timescale 1ns/1ps
module tb_mdu_core;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = 3'd7;
  logic [31:0] a_i = '0, b_i = '0;
  logic        busy_o, rd_req_i = 1'b1, rd_hi_i = 1'b0, rd_valid_o;
  logic [31:0] rd_data_o;

  int checks = 0, errors = 0;
  bit fin = 0;
  string cur_req = "R1";

  // reference model state
  logic [31:0] m_hi = '0, m_lo = '0;
  logic [63:0] m_pend = '0;
  int          m_cnt = 0;

  always #2.5 clk_i = ~clk_i;

  mdu_core dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .rd_req_i(rd_req_i),
    .rd_hi_i(rd_hi_i), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );

  function automatic logic [63:0] ref_result(input logic [2:0] op, input logic [31:0] a, b,
                                             input logic [31:0] hi, lo);
    longint q, r;
    case (op)
      3'd0: return 64'(longint'($signed(a)) * longint'($signed(b)));
      3'd1: return {32'b0, a} * {32'b0, b};
      3'd4: return {hi, lo} + 64'(longint'($signed(a)) * longint'($signed(b)));
      3'd2: begin
        if (b == 0) return {a, 32'hffffffff};
        q = longint'($signed(a)) / longint'($signed(b));
        r = longint'($signed(a)) % longint'($signed(b));
        return {r[31:0], q[31:0]};
      end
      default: begin
        if (b == 0) return {a, 32'hffffffff};
        return {a % b, a / b};
      end
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_hi = '0; m_lo = '0; m_cnt = 0;
    end else if (m_cnt != 0) begin
      m_cnt = m_cnt - 1;
      if (m_cnt == 0) {m_hi, m_lo} = m_pend;
    end else if (start_i) begin
      if (op_i <= 3'd4) begin
        m_pend = ref_result(op_i, a_i, b_i, m_hi, m_lo);
        m_cnt  = 32;
      end else if (op_i == 3'd5) m_hi = a_i;
      else if (op_i == 3'd6) m_lo = a_i;
    end
  end

  always @(posedge clk_i) begin
    #1 rd_hi_i <= ~rd_hi_i;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk_i) begin
    if (!fin) begin
      logic eb, ev;
      eb = (m_cnt != 0);
      ev = rd_req_i && !eb;
      chk("R9", 32'(busy_o), 32'(eb));
      chk("R10", 32'(rd_valid_o), 32'(ev));
      if (ev) chk(cur_req, rd_data_o, rd_hi_i ? m_hi : m_lo);
    end
  end

  task automatic issue(input string tag, input logic [2:0] op, input logic [31:0] a, b);
    @(posedge clk_i); #1;
    cur_req = tag; start_i = 1'b1; op_i = op; a_i = a; b_i = b;
    @(posedge clk_i); #1;
    start_i = 1'b0; op_i = 3'd7;
  endtask

  task automatic settle();
    while (m_cnt != 0) @(posedge clk_i);
    repeat (3) @(posedge clk_i);
  endtask

  task automatic run(input string tag, input logic [2:0] op, input logic [31:0] a, b);
    issue(tag, op, a, b);
    settle();
  endtask

  initial begin
    cur_req = "R1";
    repeat (4) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    repeat (3) @(posedge clk_i);

    run("R8", 3'd5, 32'h12345678, 0);
    run("R8", 3'd6, 32'h9abcdef0, 0);

    run("R2", 3'd0, -32'sd7, 32'd3);
    run("R2", 3'd0, 32'h80000000, 32'h80000000);
    run("R2", 3'd0, 32'd12345, -32'sd6789);

    run("R3", 3'd1, 32'hffffffff, 32'hffffffff);
    run("R3", 3'd1, 32'h00010000, 32'h00010000);

    run("R7", 3'd5, 32'h00000001, 0);
    run("R7", 3'd6, 32'hfffffff0, 0);
    run("R7", 3'd4, -32'sd2, 32'd3);
    run("R7", 3'd4, 32'h7fffffff, 32'h7fffffff);
    run("R7", 3'd5, 32'hffffffff, 0);
    run("R7", 3'd6, 32'hffffffff, 0);
    run("R7", 3'd4, 32'd1, 32'd1);

    run("R4", 3'd2, -32'sd7, 32'd2);
    run("R4", 3'd2, 32'd7, -32'sd2);
    run("R4", 3'd2, 32'h80000000, 32'hffffffff);

    run("R5", 3'd3, 32'd100, 32'd7);
    run("R5", 3'd3, 32'hffffffff, 32'd16);

    run("R6", 3'd2, -32'sd5, 32'd0);
    run("R6", 3'd3, 32'd123, 32'd0);

    // R11: commands during a run are dropped; opcode 7 is a no-op
    issue("R11", 3'd0, 32'd3, 32'd4);
    repeat (5) @(posedge clk_i);
    issue("R11", 3'd5, 32'hdeadbeef, 0);
    issue("R11", 3'd1, 32'd9, 32'd9);
    settle();
    run("R11", 3'd7, 32'hcafef00d, 32'd5);

    // R10: reads refused while busy, and off when not requested
    issue("R10", 3'd3, 32'd1000, 32'd3);
    #1 rd_req_i = 1'b0;
    repeat (4) @(posedge clk_i);
    #1 rd_req_i = 1'b1;
    settle();

    fin = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!fin) begin
      fin = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule